// File: doc/BRIEF.md
# Ramped Digital Attenuator with Soft Mute

This block scales a stereo stream of signed audio samples by a gain picked from a 7-bit attenuation code. Writing a new code does not change the gain at once. The code in effect (the applied code) moves one step toward the written target after a fixed number of input sample strobes. That number is 8 in normal-speed mode and 16 in high-speed mode, so a sweep across the whole range takes 1016 or 2032 sample periods. Because the gain changes in these small, slow steps, the output has no audible clicks.

An active-low mute input makes the target the zero-gain code, so the gain ramps down to silence at the same rate. Releasing mute ramps the gain back to the stored code. Codes written while mute is held only replace the stored value. The left and right samples of a frame share one applied code. Each scaled pair appears one clock after its input strobe.

Top module: `soft_gain_ramp`

## Requirements
- R1: Applied code 0 gives unity gain, so the output equals the input exactly. Applied code 127 gives zero output.
- R2: For applied codes 1 to 126 the output is floor(in × (127 − code) / 128), computed as a 24-by-8 product shifted right arithmetically by 7.
- R3: With high_speed low, the applied code moves one unit toward its target on every 8th sample strobe, counted from when the two differ. It holds while they are equal. It changes only in the clock after a strobe and never by more than one unit.
- R4: With high_speed high, the step interval is 16 sample strobes.
- R5: While mute_n is low the target is code 127, and the applied code ramps down at the step rate. When mute_n returns high, the applied code ramps back to the stored code.
- R6: A code written while mute_n is low only updates the stored code. The applied code keeps heading to 127, and after release it ramps to the newly written value.
- R7: out_valid pulses one clock after each smp_valid. out_left and out_right in that cycle are scaled by the applied code that was in effect at the strobe, with the same gain on both channels.
- R8: Reset clears the stored code, the applied code and the step counter to 0. It also drives out_valid, out_left and out_right to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe: a left/right sample pair is present |
| smp_left | input | 24 | Left sample, two's complement |
| smp_right | input | 24 | Right sample, two's complement |
| code_wr | input | 1 | Write strobe for code_in |
| code_in | input | 7 | New attenuation code (0 = 0 dB, 127 = silence) |
| mute_n | input | 1 | Low requests soft mute |
| high_speed | input | 1 | Low: step every 8 strobes; high: step every 16 |
| out_valid | output | 1 | Scaled pair valid |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| applied_code | output | 7 | Attenuation code currently in use |

## Verification
The scaled samples and out_valid are due one clock after the strobe. Any step of applied_code is visible in that same clock, after the strobe that completes an interval. The bench raises each strobe on a falling edge and lowers it on the next one, then checks outputs and applied_code at that second falling edge, one rising edge after the strobe. A step-interval count compares the number of strobes before applied_code first moves with 8 or 16. A reference model advances the applied code once per strobe from the requirements and predicts every sample and code. It covers random writes, mute toggles and mode changes as well as directed extreme samples.

// File: rtl/sgr_pkg.sv
package sgr_pkg;
   typedef enum logic [1:0] {
      RAMP_HOLD = 2'd0,
      RAMP_UP   = 2'd1,
      RAMP_DOWN = 2'd2
   } ramp_dir_e;
endpackage

// File: rtl/sgr_ramp_ctrl.sv
module sgr_ramp_ctrl #(
   parameter int unsigned CODE_W      = 7,
   parameter int unsigned NORM_PERIOD = 8,
   parameter int unsigned HIGH_PERIOD = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic              code_wr,
   input  logic [CODE_W-1:0] code_in,
   input  logic              mute_n,
   input  logic              high_speed,
   output logic [CODE_W-1:0] applied_code
);
   import sgr_pkg::*;

   localparam int unsigned MAX_PERIOD = (NORM_PERIOD > HIGH_PERIOD) ? NORM_PERIOD : HIGH_PERIOD;
   localparam int unsigned CNT_W      = $clog2(MAX_PERIOD + 1);
   localparam logic [CODE_W-1:0] SILENT_CODE = {CODE_W{1'b1}};

   logic [CODE_W-1:0] stored_q;
   logic [CODE_W-1:0] applied_q;
   logic [CODE_W-1:0] target;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  last_cnt;
   ramp_dir_e         dir;

   // stored code: written at any time, mute or not
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       stored_q <= '0;
      else if (code_wr) stored_q <= code_in;
   end

   always_comb begin
      target   = mute_n ? stored_q : SILENT_CODE;
      last_cnt = high_speed ? CNT_W'(HIGH_PERIOD - 1) : CNT_W'(NORM_PERIOD - 1);
      if (applied_q < target)      dir = RAMP_UP;
      else if (applied_q > target) dir = RAMP_DOWN;
      else                         dir = RAMP_HOLD;
   end

   // step divider: advances on sample strobes only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         applied_q <= '0;
         cnt_q     <= '0;
      end else if (smp_valid) begin
         if (dir == RAMP_HOLD) begin
            cnt_q <= '0;
         end else if (cnt_q >= last_cnt) begin
            cnt_q     <= '0;
            applied_q <= (dir == RAMP_UP) ? CODE_W'(applied_q + 1'b1)
                                          : CODE_W'(applied_q - 1'b1);
         end else begin
            cnt_q <= CNT_W'(cnt_q + 1'b1);
         end
      end
   end

   assign applied_code = applied_q;
endmodule

// File: rtl/sgr_gain_map.sv
module sgr_gain_map #(
   parameter int unsigned CODE_W = 7
) (
   input  logic [CODE_W-1:0] code,
   output logic [CODE_W:0]   gain
);
   localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};
   localparam logic [CODE_W:0]   UNITY    = {1'b1, {CODE_W{1'b0}}};

   // code 0 -> full scale; others -> TOP_CODE - code (top code -> 0)
   always_comb begin
      if (code == '0) gain = UNITY;
      else            gain = {1'b0, CODE_W'(TOP_CODE - code)};
   end
endmodule

// File: rtl/sgr_scaler.sv
module sgr_scaler #(
   parameter int unsigned DATA_W = 24,
   parameter int unsigned GAIN_W = 8
) (
   input  logic signed [DATA_W-1:0] sample,
   input  logic        [GAIN_W-1:0] gain,
   output logic signed [DATA_W-1:0] scaled
);
   localparam int unsigned PROD_W = DATA_W + GAIN_W + 1;
   localparam int unsigned SHIFT  = GAIN_W - 1;

   logic signed [PROD_W-1:0] s_ext;
   logic signed [PROD_W-1:0] g_ext;
   logic signed [PROD_W-1:0] prod;

   always_comb begin
      s_ext  = PROD_W'(sample);
      g_ext  = $signed({{(PROD_W-GAIN_W){1'b0}}, gain});
      prod   = s_ext * g_ext;
      scaled = DATA_W'(prod >>> SHIFT);
   end
endmodule

// File: rtl/soft_gain_ramp.sv
module soft_gain_ramp #(
   parameter int unsigned DATA_W      = 24,
   parameter int unsigned CODE_W      = 7,
   parameter int unsigned NORM_PERIOD = 8,
   parameter int unsigned HIGH_PERIOD = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     smp_valid,
   input  logic signed [DATA_W-1:0] smp_left,
   input  logic signed [DATA_W-1:0] smp_right,
   input  logic                     code_wr,
   input  logic        [CODE_W-1:0] code_in,
   input  logic                     mute_n,
   input  logic                     high_speed,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_left,
   output logic signed [DATA_W-1:0] out_right,
   output logic        [CODE_W-1:0] applied_code
);
   localparam int unsigned NUM_CH = 2;
   localparam int unsigned GAIN_W = CODE_W + 1;

   if (CODE_W < 2) begin : g_chk_code
      $error("soft_gain_ramp: CODE_W must be at least 2");
   end
   if (DATA_W <= GAIN_W) begin : g_chk_data
      $error("soft_gain_ramp: DATA_W must exceed CODE_W + 1");
   end
   if (NORM_PERIOD < 1 || HIGH_PERIOD < 1) begin : g_chk_period
      $error("soft_gain_ramp: step periods must be at least 1");
   end

   logic [GAIN_W-1:0]        gain;
   logic signed [DATA_W-1:0] ch_in  [NUM_CH];
   logic signed [DATA_W-1:0] ch_mul [NUM_CH];
   logic signed [DATA_W-1:0] ch_out [NUM_CH];

   sgr_ramp_ctrl #(
      .CODE_W     (CODE_W),
      .NORM_PERIOD(NORM_PERIOD),
      .HIGH_PERIOD(HIGH_PERIOD)
   ) u_ramp (
      .clk         (clk),
      .rst_n       (rst_n),
      .smp_valid   (smp_valid),
      .code_wr     (code_wr),
      .code_in     (code_in),
      .mute_n      (mute_n),
      .high_speed  (high_speed),
      .applied_code(applied_code)
   );

   sgr_gain_map #(.CODE_W(CODE_W)) u_map (
      .code(applied_code),
      .gain(gain)
   );

   assign ch_in[0] = smp_left;
   assign ch_in[1] = smp_right;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      sgr_scaler #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_scale (
         .sample(ch_in[ch]),
         .gain  (gain),
         .scaled(ch_mul[ch])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         ch_out[ch] <= '0;
         else if (smp_valid) ch_out[ch] <= ch_mul[ch];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= smp_valid;
   end

   assign out_left  = ch_out[0];
   assign out_right = ch_out[1];
endmodule

// File: rtl/sgr_checker.sv
module sgr_checker #(
   parameter int unsigned DATA_W = 24,
   parameter int unsigned CODE_W = 7
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     smp_valid,
   input logic signed [DATA_W-1:0] smp_left,
   input logic signed [DATA_W-1:0] smp_right,
   input logic                     mute_n,
   input logic                     out_valid,
   input logic signed [DATA_W-1:0] out_left,
   input logic signed [DATA_W-1:0] out_right,
   input logic        [CODE_W-1:0] applied_code
);
   localparam logic [CODE_W-1:0] SILENT = {CODE_W{1'b1}};

   AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && applied_code == '0) |=>
      (out_left == $past(smp_left) && out_right == $past(smp_right))); // R1

   AST_SILENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && applied_code == SILENT) |=> (out_left == '0 && out_right == '0)); // R1

   AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (applied_code != $past(applied_code)) |->
      (applied_code == CODE_W'($past(applied_code) + 1'b1) ||
       applied_code == CODE_W'($past(applied_code) - 1'b1))); // R3

   AST_STEP_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> $stable(applied_code)); // R3

   AST_MUTE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mute_n && smp_valid) |=> (applied_code >= $past(applied_code))); // R5

   AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> out_valid); // R7

   AST_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> !out_valid); // R7
endmodule

bind soft_gain_ramp sgr_checker #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .smp_valid   (smp_valid),
   .smp_left    (smp_left),
   .smp_right   (smp_right),
   .mute_n      (mute_n),
   .out_valid   (out_valid),
   .out_left    (out_left),
   .out_right   (out_right),
   .applied_code(applied_code)
);

// File: tb/sim_soft_gain_ramp.sv
module sim_soft_gain_ramp;
   localparam int DW   = 24;
   localparam int CW   = 7;
   localparam int NP   = 8;
   localparam int HP   = 16;
   localparam int MAXC = 127;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_valid = 1'b0;
   logic code_wr = 1'b0;
   logic mute_n = 1'b1;
   logic high_speed = 1'b0;
   logic signed [DW-1:0] smp_left = '0;
   logic signed [DW-1:0] smp_right = '0;
   logic [CW-1:0] code_in = '0;
   wire out_valid;
   wire signed [DW-1:0] out_left;
   wire signed [DW-1:0] out_right;
   wire [CW-1:0] applied_code;

   int n_chk = 0;
   int n_fail = 0;
   int m_stored = 0;
   int m_applied = 0;
   int m_cnt = 0;

   always #10 clk = ~clk;

   soft_gain_ramp u0 (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
      .smp_left(smp_left), .smp_right(smp_right),
      .code_wr(code_wr), .code_in(code_in), .mute_n(mute_n),
      .high_speed(high_speed), .out_valid(out_valid),
      .out_left(out_left), .out_right(out_right),
      .applied_code(applied_code)
   );

   function automatic logic signed [DW-1:0] ref_scale(logic signed [DW-1:0] x, int code);
      longint g;
      longint p;
      if (code == 0) g = 128;
      else           g = 127 - code;
      p = longint'(x) * g;
      return DW'(p >>> 7);
   endfunction

   task automatic chk(string req, longint act, longint exp, string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic model_strobe();
      int tgt = mute_n ? m_stored : MAXC;
      int per = high_speed ? HP : NP;
      if (m_applied == tgt) m_cnt = 0;
      else if (m_cnt >= per - 1) begin
         m_cnt = 0;
         m_applied += (m_applied < tgt) ? 1 : -1;
      end else m_cnt++;
   endtask

   task automatic strobe_d(string req, logic signed [DW-1:0] l, logic signed [DW-1:0] r);
      int code_before = m_applied;
      @(negedge clk);
      chk("R7", out_valid, 0, "out_valid idle");
      smp_valid = 1'b1; smp_left = l; smp_right = r;
      @(negedge clk);
      smp_valid = 1'b0;
      model_strobe();
      chk("R7", out_valid, 1, "out_valid");
      chk(req, out_left,  ref_scale(l, code_before), "out_left");
      chk(req, out_right, ref_scale(r, code_before), "out_right");
      chk(req, applied_code, m_applied, "applied_code");
   endtask

   task automatic strobe(string req);
      strobe_d(req, DW'($urandom), DW'($urandom));
   endtask

   task automatic write_code(int c);
      @(negedge clk);
      code_wr = 1'b1; code_in = CW'(c);
      @(negedge clk);
      code_wr = 1'b0;
      m_stored = c;
   endtask

   task automatic settle(string req);
      int guard = 0;
      while (m_applied != (mute_n ? m_stored : MAXC) && guard < 5000) begin
         strobe(req);
         guard++;
      end
   endtask

   task automatic measure(string req, int c, int exp);
      int k = 0;
      int start = m_applied;
      write_code(c);
      do begin
         strobe(req);
         k++;
      end while (int'(applied_code) == start && k < 100);
      chk(req, k, exp, "strobes per step");
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      chk("R8", out_valid, 0, "reset out_valid");
      chk("R8", out_left, 0, "reset out_left");
      chk("R8", applied_code, 0, "reset applied_code");
      rst_n = 1'b1;

      // R1 unity at code 0
      strobe_d("R1", 24'sh7FFFFF, -24'sh800000);
      strobe_d("R1", -24'sd1, 24'sd1);
      strobe("R1");

      // R3 step interval, normal speed
      measure("R3", 5, NP);
      settle("R3");
      chk("R3", applied_code, 5, "settled code");
      strobe("R3");
      chk("R3", applied_code, 5, "hold at target");

      // R2 gain points
      write_code(1);   settle("R2");
      strobe_d("R2", 24'sh7FFFFF, -24'sh800000);
      write_code(63);  settle("R2");
      strobe_d("R2", 24'sh400000, -24'sd3);
      write_code(126); settle("R2");
      strobe_d("R2", 24'sh7FFFFF, -24'sh800000);
      strobe_d("R2", -24'sd1, 24'sd200);

      // R1 silence at code 127
      write_code(127); settle("R1");
      strobe_d("R1", 24'sh7FFFFF, -24'sh800000);

      // R4 step interval, high speed
      high_speed = 1'b1;
      measure("R4", 120, HP);
      settle("R4");
      chk("R4", applied_code, 120, "settled code");
      high_speed = 1'b0;

      // R5 soft mute down and back
      write_code(10); settle("R5");
      mute_n = 1'b0;
      begin
         int k = 0;
         do begin strobe("R5"); k++; end while (applied_code == 10 && k < 100);
         chk("R5", k, NP, "mute step interval");
      end
      settle("R5");
      chk("R5", applied_code, MAXC, "muted code");
      mute_n = 1'b1;
      settle("R5");
      chk("R5", applied_code, 10, "restored code");

      // R6 write while muted
      mute_n = 1'b0;
      settle("R6");
      write_code(40);
      repeat (12) strobe("R6");
      chk("R6", applied_code, MAXC, "still muted");
      mute_n = 1'b1;
      settle("R6");
      chk("R6", applied_code, 40, "ramped to new code");

      // random mix
      for (int it = 0; it < 40; it++) begin
         int act = $urandom_range(0, 3);
         if (act == 0)      write_code($urandom_range(0, MAXC));
         else if (act == 1) mute_n = ~mute_n;
         else if (act == 2) high_speed = ~high_speed;
         else               write_code($urandom_range(0, 20));
         repeat ($urandom_range(1, 60)) strobe("R3");
      end
      mute_n = 1'b1;
      high_speed = 1'b0;

      // R8 reset in mid-run
      write_code(90);
      repeat (20) strobe("R8");
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R8", applied_code, 0, "reset applied_code");
      chk("R8", out_left, 0, "reset out_left");
      chk("R8", out_right, 0, "reset out_right");
      rst_n = 1'b1;
      m_stored = 0; m_applied = 0; m_cnt = 0;
      repeat (10) strobe("R8");
      chk("R8", applied_code, 0, "stored cleared");

      report();
      $finish;
   end
endmodule